// File: doc/BRIEF.md
# Sinusoid Table Waveform Generator

This block produces a stream of signed 16-bit sinusoid samples for an external DAC. It holds two fixed tables of 1000 entries each. One table holds a single-tone sinusoid. The other holds a mix of a fundamental and its third harmonic. The table address moves forward by a programmable step. The update happens once every programmable number of system clocks. So the output frequency is `step / (1000 * interval * Tclk)`. With a 100 MHz clock, this covers roughly 10 Hz (step 1, interval 10000) up to 500 kHz (step 5, interval 1).

Each sample is scaled by a signed Q1.15 gain. It is presented with a one-cycle valid strobe and the table index it came from, so a demodulator can use the same reference phase. A one-cycle period-start pulse marks the first sample of every sinusoid period. Settings are meant to be reloaded for each projection. The block takes a new setting only at a period boundary, so no period is ever built from two settings.

Top module: `sine_rom_gen`

## Requirements
- R1: Entry `a` of the pure table is defined by two halves. For `a` below 500, it is `s(a) = (16*32767*u) / (1250000 - 4*u)` with `u = a*(500-a)`, using truncating integer division. For `a` from 500 up, it is `-s(a-500)`. Entry `a` of the mixed table is `(pure[a] + pure[(3*a) mod 1000]) >>> 1`, using an arithmetic shift. `tone_sel` = 0 picks the pure table and 1 picks the mixed table.
- R2: When `run` is first sampled high while the block is idle, the next clock edge presents a sample. That sample has `sample_vld` = 1, `addr_out` = 0 and `cycle_start` = 1.
- R3: Each address update adds the step modulo 1000. A `step_in` above 999 is used as 999. A step of 0 holds the address.
- R4: Address updates, and so `sample_vld` strobes, are exactly `interval_in` clocks apart. An `interval_in` of 0 behaves as 1.
- R5: `cycle_start` is high only together with `sample_vld`. It is high on the first sample after start and on every sample whose address wrapped, meaning the previous address plus the step reached 1000 or more.
- R6: `sample_out` equals `(table_value * gain + 16384) >>> 15`, taken to 16 bits. Both factors are signed, and the gain is Q1.15.
- R7: All four settings are captured at start and again on each wrap. Changes to the inputs at any other time have no effect. On a wrap, the sample that carries `cycle_start` already uses the new table and gain. The new step and interval apply from the following update onward.
- R8: Once `run` has been low at two successive clock edges, `sample_vld` and `cycle_start` stay low. `sample_out` and `addr_out` also hold their values.
- R9: After reset, all outputs are zero.
- R10: `addr_out` is the table index of the sample shown in the same cycle. It is always below 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Generation enable; a rising level restarts at address 0 |
| tone_sel | input | 1 | 0: pure table, 1: mixed table |
| step_in | input | 10 | Address increment per update |
| interval_in | input | 16 | Clocks between address updates |
| gain_in | input | 16 | Signed Q1.15 amplitude |
| sample_out | output | 16 | Scaled signed sample |
| sample_vld | output | 1 | One-cycle strobe per new sample |
| addr_out | output | 10 | Table index of the current sample |
| cycle_start | output | 1 | First sample of a sinusoid period |

## Verification
A wrap does two things in the same clock: it raises the period-start pulse, and it swaps in the pending settings. The first sample of the new period must therefore show the new table and gain, while its spacing from the previous sample still follows the old interval. The bench provokes this by changing all four settings one cycle after start, well before the first wrap. It uses a step of 250, so the wrap lands exactly on address 0, and then a step of 333, which overshoots. The scoreboard checks that the samples before the wrap are untouched by the change. It also checks that, from the wrap onward, value, index, pulse and spacing follow the new setting.

// File: rtl/sine_rom_gen.sv
module sine_rom_gen #(
  parameter int DEPTH = 1000,
  parameter int SW    = 16,
  parameter int CW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tone_sel,
  input  logic [AW-1:0] step_in,
  input  logic [CW-1:0] interval_in,
  input  logic [SW-1:0] gain_in,
  output logic [SW-1:0] sample_out,
  output logic          sample_vld,
  output logic [AW-1:0] addr_out,
  output logic          cycle_start
);

  localparam int HALF = DEPTH / 2;
  localparam int AMP  = 2 ** (SW - 1) - 1;
  localparam logic [AW:0]   DEPTH_V = (AW + 1)'(DEPTH);
  localparam logic [AW-1:0] STEP_MAX = AW'(DEPTH - 1);
  localparam logic signed [2*SW-1:0] RND = (2 * SW)'(1) << (SW - 2);

  function automatic logic signed [SW-1:0] pure_val(input int a);
    longint h, p, u, m;
    h = longint'(HALF);
    p = longint'((a < HALF) ? a : a - HALF);
    u = p * (h - p);
    m = (16 * longint'(AMP) * u) / (5 * h * h - 4 * u);
    if (a >= HALF) m = -m;
    return SW'(m);
  endfunction

  function automatic logic signed [SW-1:0] mix_val(input int a);
    longint x;
    x = longint'(pure_val(a)) + longint'(pure_val((3 * a) % DEPTH));
    return SW'(x >>> 1);
  endfunction

  logic signed [SW-1:0] pure_tbl [DEPTH];
  logic signed [SW-1:0] mix_tbl  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign pure_tbl[g] = pure_val(g);
    assign mix_tbl[g]  = mix_val(g);
  end

  logic                 running, tick, wrap_q;
  logic [AW-1:0]        addr_q, step_q;
  logic [CW-1:0]        cnt_q, intv_q;
  logic signed [SW-1:0] gain_q;
  logic                 sel_q;

  logic [AW:0]   sum_w;
  logic          wraps_w;
  logic [AW-1:0] next_w, step_clip_w;
  logic [CW-1:0] last_cnt_w;

  assign sum_w       = {1'b0, addr_q} + {1'b0, step_q};
  assign wraps_w     = sum_w >= DEPTH_V;
  assign next_w      = wraps_w ? AW'(sum_w - DEPTH_V) : sum_w[AW-1:0];
  assign step_clip_w = (step_in > STEP_MAX) ? STEP_MAX : step_in;
  assign last_cnt_w  = (intv_q == '0) ? '0 : intv_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tick    <= 1'b0;
      wrap_q  <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      step_q  <= '0;
      intv_q  <= '0;
      gain_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      tick   <= 1'b0;
      wrap_q <= 1'b0;
      if (!run) begin
        running <= 1'b0;
      end else if (!running) begin
        running <= 1'b1;
        addr_q  <= '0;
        cnt_q   <= '0;
        tick    <= 1'b1;
        wrap_q  <= 1'b1;
        step_q  <= step_clip_w;
        intv_q  <= interval_in;
        gain_q  <= gain_in;
        sel_q   <= tone_sel;
      end else if (cnt_q == last_cnt_w) begin
        cnt_q  <= '0;
        addr_q <= next_w;
        tick   <= 1'b1;
        if (wraps_w) begin
          wrap_q <= 1'b1;
          step_q <= step_clip_w;
          intv_q <= interval_in;
          gain_q <= gain_in;
          sel_q  <= tone_sel;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  logic signed [SW-1:0]   raw_w, scaled_w;
  logic signed [2*SW-1:0] prod_w;

  assign raw_w    = sel_q ? mix_tbl[addr_q] : pure_tbl[addr_q];
  assign prod_w   = raw_w * gain_q;
  assign scaled_w = SW'((prod_w + RND) >>> (SW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out  <= '0;
      addr_out    <= '0;
      sample_vld  <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      sample_vld  <= tick;
      cycle_start <= wrap_q;
      if (tick) begin
        sample_out <= scaled_w;
        addr_out   <= addr_q;
      end
    end
  end

endmodule

// File: rtl/sine_rom_gen_chk.sv
module sine_rom_gen_chk #(
  parameter int DEPTH = 1000,
  parameter int SW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [SW-1:0] sample_out,
  input logic          sample_vld,
  input logic [AW-1:0] addr_out,
  input logic          cycle_start
);

  logic [AW-1:0] last_addr;
  logic          have_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_last <= 1'b0;
    end else if (sample_vld) begin
      last_addr <= addr_out;
      have_last <= 1'b1;
    end
  end

  a_r5_pulse_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> sample_vld);

  a_r10_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (addr_out < AW'(DEPTH)));

  a_r5_wrap_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && have_last && (addr_out < last_addr)) |-> cycle_start);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(run, 2)) |-> (!sample_vld && !cycle_start));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> ($stable(sample_out) && $stable(addr_out)));

endmodule

bind sine_rom_gen sine_rom_gen_chk #(.DEPTH(DEPTH), .SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sample_out(sample_out),
  .sample_vld(sample_vld), .addr_out(addr_out), .cycle_start(cycle_start)
);

// File: tb/tb_sine_rom_gen.sv
module tb_sine_rom_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        tone_sel = 1'b0;
  logic [9:0]  step_in = '0;
  logic [15:0] interval_in = '0;
  logic [15:0] gain_in = '0;
  logic [15:0] sample_out;
  logic        sample_vld;
  logic [9:0]  addr_out;
  logic        cycle_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sine_rom_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .tone_sel(tone_sel),
    .step_in(step_in), .interval_in(interval_in), .gain_in(gain_in),
    .sample_out(sample_out), .sample_vld(sample_vld),
    .addr_out(addr_out), .cycle_start(cycle_start)
  );

  typedef struct { int a; int v; bit s; int gap; } exp_t;
  exp_t q[$];

  function automatic int pure_ref(int a);
    longint p, u, m;
    p = (a < 500) ? a : a - 500;
    u = p * (500 - p);
    m = (16 * 32767 * u) / (1250000 - 4 * u);
    return int'((a < 500) ? m : -m);
  endfunction

  function automatic int tbl_ref(bit sel, int a);
    if (!sel) return pure_ref(a);
    return (pure_ref(a) + pure_ref((3 * a) % 1000)) >>> 1;
  endfunction

  function automatic int scale_ref(int v, int g);
    longint p;
    p = longint'(v) * longint'(g);
    return int'((p + 16384) >>> 15);
  endfunction

  // R2 R3 R4 R5 R6 R7 model: settings A at start, settings B from the first wrap
  task automatic play(input bit s0, input int st0, input int iv0, input int g0,
                      input bit chg, input bit s1, input int st1, input int iv1,
                      input int g1, input int n);
    bit cs; int cst, civ, cg, a, gap;
    bit w; logic [15:0] hold_s; logic [9:0] hold_a; bit ok;
    cs = s0; cst = (st0 > 999) ? 999 : st0; civ = (iv0 == 0) ? 1 : iv0; cg = g0;
    a = 0;
    q.push_back('{a: 0, v: scale_ref(tbl_ref(cs, 0), cg), s: 1'b1, gap: 0});
    for (int k = 1; k < n; k++) begin
      gap = civ;
      a = a + cst;
      w = (a >= 1000);
      if (w) a = a - 1000;
      if (w && chg) begin
        cs = s1; cst = (st1 > 999) ? 999 : st1; civ = (iv1 == 0) ? 1 : iv1; cg = g1;
      end
      q.push_back('{a: a, v: scale_ref(tbl_ref(cs, a), cg), s: w, gap: gap});
    end
    @(negedge clk);
    tone_sel = s0; step_in = 10'(st0); interval_in = 16'(iv0); gain_in = 16'(g0);
    run = 1'b1;
    @(negedge clk);
    if (chg) begin
      tone_sel = s1; step_in = 10'(st1); interval_in = 16'(iv1); gain_in = 16'(g1);
    end
    while (q.size() != 0) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    hold_s = sample_out; hold_a = addr_out; ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (sample_vld || cycle_start || sample_out != hold_s || addr_out != hold_a) ok = 1'b0;
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R8 idle after stop: vld=%0b start=%0b sample=%0h addr=%0d expected vld=0 start=0 sample=%0h addr=%0d",
               sample_vld, cycle_start, sample_out, addr_out, hold_s, hold_a);
    end
  endtask

  int since = 0;
  initial forever begin
    @(negedge clk);
    since++;
    if (rst_n && sample_vld) begin
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(addr_out) != e.a) begin
          errors++;
          $display("FAIL R3/R10 addr: got %0d expected %0d", addr_out, e.a);
        end else if (int'($signed(sample_out)) != e.v) begin
          errors++;
          $display("FAIL R1/R6 sample at addr %0d: got %0d expected %0d", e.a, $signed(sample_out), e.v);
        end else if (cycle_start != e.s) begin
          errors++;
          $display("FAIL R5/R7 period start at addr %0d: got %0b expected %0b", e.a, cycle_start, e.s);
        end else if (e.gap != 0 && since != e.gap) begin
          errors++;
          $display("FAIL R4 spacing at addr %0d: got %0d expected %0d", e.a, since, e.gap);
        end
      end
      since = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (sample_vld || cycle_start || sample_out != 16'h0 || addr_out != 10'h0) begin
      errors++;
      $display("FAIL R9 reset: vld=%0b start=%0b sample=%0h addr=%0d expected all zero",
               sample_vld, cycle_start, sample_out, addr_out);
    end
    // R1 R2 R3 R5: pure table, full period plus wrap, unity gain
    play(1'b0, 1, 1, 32767, 1'b0, 1'b0, 0, 0, 0, 1010);
    // R1 R4 R6: mixed table, odd step, interval 3, negative gain
    play(1'b1, 7, 3, -16384, 1'b0, 1'b0, 0, 0, 0, 300);
    // R7: change mid-period, exact wrap at 1000 then overshooting step
    play(1'b0, 250, 2, 32767, 1'b1, 1'b1, 333, 5, -32768, 20);
    // R3 R4: zero step holds address, zero interval acts as one
    play(1'b1, 0, 0, 20000, 1'b0, 1'b0, 0, 0, 0, 12);
    // R3: oversized step clipped to 999
    play(1'b0, 1023, 4, 12345, 1'b0, 1'b0, 0, 0, 0, 15);
    // R2 R7: restart with settings change ignored before the wrap
    play(1'b1, 3, 2, 32767, 1'b1, 1'b0, 500, 1, 1000, 700);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule